// File: doc/BRIEF.md
# Sign-Weighted SIMD Accumulate Unit

This execution unit keeps a small matrix of packed accumulators: ROWS rows, each one word of LANES signed lanes of LANE_W bits (8 rows of eight 8-bit lanes by default). A command names a row `i` and carries a packed data word `C`. Every lane `j` of row `i` then takes `D[i][j] + s[i]*C[j]`, where `s[i]` is a +1/-1 symbol held in a per-row sign register. The multiply by a symbol is done as a per-lane add or subtract, so no multiplier is used. All lanes of the row are updated in the cycle the command is accepted.

The sign register is loaded as a whole through its own port. A synchronous clear empties the whole matrix. A registered read port returns one row a cycle after its index is presented. Lane arithmetic wraps in two's complement by default. A parameter switches every lane to clamping at the signed limits instead. This unit is typically used to build cross-correlation tables: software loads a symbol vector, then streams one data word per row.

Top module: `simd_sign_mac`

## Requirements
- R1: After reset is released, every accumulator lane reads back as zero, the sign register is all zeros, and `rd_data` is zero.
- R2: `cmd_ready` is high in every cycle, so one command is accepted per clock.
- R3: When `cmd_valid` is high and sign bit `cmd_row` of the stored sign register is 1 (+1), lane j of row `cmd_row` becomes its old value plus lane j of `cmd_data` at that clock edge. Lane j occupies bits [8j+7:8j], with lane 0 in the least significant byte.
- R4: When the selected sign bit is 0 (-1), lane j of the row becomes its old value minus lane j of `cmd_data`.
- R5: An update changes no row other than `cmd_row`.
- R6: With SATURATE=0, a lane result that leaves [-128, 127] wraps modulo 256.
- R7: With SATURATE=1, a lane result above 127 becomes 127 and one below -128 becomes -128.
- R8: `clr` high zeroes all lanes of all rows at the next edge. If a command arrives in the same cycle, the clear wins and the command has no effect.
- R9: `rd_data` shows row `rd_row` one cycle after `rd_row` is presented. The value is the row as it stood before any update or clear taken at that same edge.
- R10: `sign_load` replaces the sign register with `sign_value`. A command in the same cycle uses the sign bits held before that load.
- R11: With `cmd_valid` and `clr` both low, no accumulator lane changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Update command present |
| cmd_ready | output | 1 | Command accepted (always high) |
| cmd_row | input | $clog2(ROWS) | Row to update, also selects the sign bit |
| cmd_data | input | LANES*LANE_W | Packed lane operands C |
| sign_load | input | 1 | Load the sign register |
| sign_value | input | ROWS | New sign bits, 1 = +1, 0 = -1 |
| clr | input | 1 | Zero the whole matrix |
| rd_row | input | $clog2(ROWS) | Row to read |
| rd_data | output | LANES*LANE_W | Registered row readback |

## Verification
Several operations can land on the same edge: a command together with a clear, a command together with a sign load, and a read of the very row that is being updated. The bench drives each of these pairs on purpose. Its behavioural model applies the stated orderings: a clear overrides the command, the command uses the old sign bits, and a read returns the contents from before the edge. The bench compares the model against `rd_data` of both a wrapping and a saturating instance on every clock.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;
  // symbol carried by one bit of the sign register
  typedef enum logic {
    SYM_NEG = 1'b0,
    SYM_POS = 1'b1
  } sym_t;
endpackage

// File: rtl/sm_lane.sv
module sm_lane #(
  parameter int W   = 8,
  parameter int SAT = 0
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  logic         pos_i,
  output logic [W-1:0] res_o
);
  generate
    if (SAT != 0) begin : g_sat
      logic [W:0] ext;
      always_comb begin
        if (pos_i) ext = {acc_i[W-1], acc_i} + {opnd_i[W-1], opnd_i};
        else       ext = {acc_i[W-1], acc_i} - {opnd_i[W-1], opnd_i};
        if (ext[W] != ext[W-1]) begin
          if (ext[W]) res_o = {1'b1, {(W-1){1'b0}}};
          else        res_o = {1'b0, {(W-1){1'b1}}};
        end else begin
          res_o = ext[W-1:0];
        end
      end
      // R7: two non-negatives added never give a negative, and a negative minus a non-negative never gives a non-negative
      always_comb begin
        if (pos_i && !acc_i[W-1] && !opnd_i[W-1])
          p_sat_pos_r7: assert (!res_o[W-1]);
        if (!pos_i && acc_i[W-1] && !opnd_i[W-1])
          p_sat_neg_r7: assert (res_o[W-1]);
      end
    end else begin : g_wrap
      always_comb begin
        if (pos_i) res_o = acc_i + opnd_i;
        else       res_o = acc_i - opnd_i;
      end
    end
  endgenerate
endmodule

// File: rtl/sm_row.sv
module sm_row #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  parameter int SAT    = 0,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic [WORD_W-1:0] row_i,
  input  logic [WORD_W-1:0] opnd_i,
  input  logic              pos_i,
  output logic [WORD_W-1:0] row_o
);
  generate
    for (genvar j = 0; j < LANES; j++) begin : g_lane
      sm_lane #(.W(LANE_W), .SAT(SAT)) u_lane (
        .acc_i (row_i[j*LANE_W +: LANE_W]),
        .opnd_i(opnd_i[j*LANE_W +: LANE_W]),
        .pos_i (pos_i),
        .res_o (row_o[j*LANE_W +: LANE_W])
      );
    end
  endgenerate
endmodule

// File: rtl/sm_bank.sv
module sm_bank #(
  parameter int ROWS   = 8,
  parameter int WORD_W = 64,
  localparam int RW    = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [RW-1:0]     wr_row_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] sel_row_o,
  input  logic [RW-1:0]     rd_row_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [ROWS-1:0][WORD_W-1:0] mem_q, mem_d;
  logic                        mem_en;
  logic [WORD_W-1:0]           rd_d;

  assign sel_row_o = mem_q[wr_row_i];
  assign mem_en    = clr_i | wr_en_i;
  assign rd_d      = mem_q[rd_row_i];

  always_comb begin
    mem_d = mem_q;
    if (clr_i)        mem_d = '0;
    else if (wr_en_i) mem_d[wr_row_i] = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mem_q <= '0;
    else if (mem_en) mem_q <= mem_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data_o <= '0;
    else        rd_data_o <= rd_d;
  end

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (mem_q == '0));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !wr_en_i) |=> $stable(mem_q));

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_hold
      p_row_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !clr_i && (wr_row_i != RW'(r))) |=> $stable(mem_q[r]));
    end
  endgenerate
endmodule

// File: rtl/simd_sign_mac.sv
module simd_sign_mac #(
  parameter int LANES    = 8,
  parameter int LANE_W   = 8,
  parameter int ROWS     = 8,
  parameter int SATURATE = 0,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int WORD_W  = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic              sign_load,
  input  logic [ROWS-1:0]   sign_value,
  input  logic              clr,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [WORD_W-1:0] rd_data
);
  import simd_mac_pkg::*;

  logic [ROWS-1:0]   sign_q, sign_d;
  logic [WORD_W-1:0] old_row, new_row;
  sym_t              sym;

  assign cmd_ready = 1'b1;
  assign sym       = sym_t'(sign_q[cmd_row]);

  always_comb begin
    sign_d = sign_q;
    if (sign_load) sign_d = sign_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sign_q <= '0;
    else if (sign_load) sign_q <= sign_d;
  end

  sm_row #(.LANES(LANES), .LANE_W(LANE_W), .SAT(SATURATE)) u_row (
    .row_i (old_row),
    .opnd_i(cmd_data),
    .pos_i (sym == SYM_POS),
    .row_o (new_row)
  );

  sm_bank #(.ROWS(ROWS), .WORD_W(WORD_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr),
    .wr_en_i  (cmd_valid),
    .wr_row_i (cmd_row),
    .wr_data_i(new_row),
    .sel_row_o(old_row),
    .rd_row_i (rd_row),
    .rd_data_o(rd_data)
  );

  p_ready_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready);

  p_sign_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sign_load |=> $stable(sign_q));
endmodule

// File: tb/simd_sign_mac_test.sv
module simd_sign_mac_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, sign_load, clr;
  logic [2:0]  cmd_row, rd_row;
  logic [63:0] cmd_data;
  logic [7:0]  sign_value;
  logic        ready_w, ready_s;
  logic [63:0] rd_w, rd_s;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int   m_w [8][8];
  int   m_s [8][8];
  logic [7:0] sgn;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_sign_mac #(.SATURATE(0)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(ready_w),
    .cmd_row(cmd_row), .cmd_data(cmd_data), .sign_load(sign_load),
    .sign_value(sign_value), .clr(clr), .rd_row(rd_row), .rd_data(rd_w));

  simd_sign_mac #(.SATURATE(1)) uut_sat (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(ready_s),
    .cmd_row(cmd_row), .cmd_data(cmd_data), .sign_load(sign_load),
    .sign_value(sign_value), .clr(clr), .rd_row(rd_row), .rd_data(rd_s));

  function automatic logic [63:0] pack_row(input bit sat, input int r);
    logic [63:0] w;
    for (int j = 0; j < 8; j++)
      w[8*j +: 8] = sat ? 8'(m_s[r][j]) : 8'(m_w[r][j]);
    return w;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive, advance the model, compare after the edge
  task automatic step(input string tag, input bit v, input int row, input logic [63:0] data,
                      input bit ld, input logic [7:0] sv, input bit cl, input int rrow);
    logic [63:0] exp_w, exp_s;
    cmd_valid = v; cmd_row = 3'(row); cmd_data = data;
    sign_load = ld; sign_value = sv; clr = cl; rd_row = 3'(rrow);
    exp_w = pack_row(0, rrow);
    exp_s = pack_row(1, rrow);
    if (cl) begin
      for (int r = 0; r < 8; r++)
        for (int j = 0; j < 8; j++) begin m_w[r][j] = 0; m_s[r][j] = 0; end
    end else if (v) begin
      for (int j = 0; j < 8; j++) begin
        int c, tw, ts;
        c  = int'($signed(data[8*j +: 8]));
        if (!sgn[row]) c = -c;
        tw = m_w[row][j] + c;
        ts = m_s[row][j] + c;
        m_w[row][j] = int'($signed(8'(tw)));
        m_s[row][j] = (ts > 127) ? 127 : ((ts < -128) ? -128 : ts);
      end
    end
    if (ld) sgn = sv;
    @(posedge clk);
    #1;
    check({tag, " wrap"}, rd_w, exp_w);
    check({tag, " sat"},  rd_s, exp_s);
    check("R2 ready", {62'd0, ready_w, ready_s}, 64'd3);
  endtask

  task automatic idle_read(input string tag, input int rrow);
    step(tag, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 8'h00, 0, rrow);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_row = 0; cmd_data = 0;
    sign_load = 0; sign_value = 0; clr = 0; rd_row = 0;
    sgn = 8'h00;
    for (int r = 0; r < 8; r++)
      for (int j = 0; j < 8; j++) begin m_w[r][j] = 0; m_s[r][j] = 0; end
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset rd wrap", rd_w, 64'd0);
    check("R1 reset rd sat",  rd_s, 64'd0);
    @(negedge clk); rst_n = 1;
    for (int r = 0; r < 8; r++) idle_read("R1 rows zero", r);
    // R1: reset sign is -1 everywhere, so a command subtracts
    step("R1 sign reset", 1, 1, 64'h0102_0304_0506_0708, 0, 0, 0, 0);
    idle_read("R4 subtract", 1);
    // R3: load +1 for rows 0,2,5,7
    step("R10 load", 0, 0, 0, 1, 8'b1010_0101, 0, 0);
    step("R3 add", 1, 0, 64'h7F80_0110_F0FF_2A05, 0, 0, 0, 0);
    idle_read("R3 add readback", 0);
    step("R4 sub", 1, 3, 64'h1122_3344_5566_7788, 0, 0, 0, 0);
    idle_read("R4 sub readback", 3);
    // R5: row 2 written, neighbours read back
    step("R5 write", 1, 2, 64'h0505_0505_0505_0505, 0, 0, 0, 2);
    idle_read("R5 other row", 3);
    idle_read("R5 other row", 1);
    // R6/R7: overflow both directions
    step("R6 acc", 1, 5, 64'h7F7F_7F7F_8080_8080, 0, 0, 0, 5);
    step("R6 overflow", 1, 5, 64'h7F01_4000_8001_C000, 0, 0, 0, 5);
    idle_read("R7 clamp", 5);
    step("R7 neg acc", 1, 4, 64'h7F7F_7F7F_7F7F_7F7F, 0, 0, 0, 4);
    step("R7 underflow", 1, 4, 64'h7F7F_0102_8080_7F00, 0, 0, 0, 4);
    idle_read("R6 underflow wrap", 4);
    // R9: read the row being written in the same cycle
    step("R9 read during write", 1, 0, 64'h0101_0101_0101_0101, 0, 0, 0, 0);
    idle_read("R9 next cycle", 0);
    // R10: load and command together use old sign of row 6 (-1)
    step("R10 same cycle", 1, 6, 64'h1010_1010_1010_1010, 1, 8'hFF, 0, 6);
    step("R10 new sign", 1, 6, 64'h0303_0303_0303_0303, 0, 0, 0, 6);
    idle_read("R10 readback", 6);
    // R11: valid low with data and a row
    step("R11 no valid", 0, 6, 64'h7777_7777_7777_7777, 0, 0, 0, 6);
    idle_read("R11 unchanged", 6);
    // R8: clear with a command
    step("R8 clear+cmd", 1, 6, 64'h2222_2222_2222_2222, 0, 0, 1, 6);
    for (int r = 0; r < 8; r++) idle_read("R8 cleared", r);
    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      step("R3 R4 R6 R7 mixed", ($urandom % 4) != 0, int'($urandom % 8), d,
           ($urandom % 16) == 0, 8'($urandom), ($urandom % 64) == 0, int'($urandom % 8));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule